// File: doc/BRIEF.md
# Integer Execute Stage with Immediate Decode

This block is the combinational execute stage of a small 32-bit load-store processor. Each cycle it is given a 32-bit instruction word and the two register values named by that instruction (`src_a` for the first source field and `src_b` for the second). It decodes the instruction and produces the 32-bit result, the index of the register to write, a write-enable, and a flag that marks an unknown encoding.

Register-format instructions use opcode 0 and select their operation through the function field. Immediate-format instructions take their second operand from the 16-bit constant. Each opcode decides whether that constant is sign-extended or zero-extended. The register file, memory access, branches, multiply/divide and overflow traps sit outside this block.

Top module: `int_exec_unit`

## Requirements
- R1: The opcode is instr[31:26], the first source index instr[25:21], the second source index instr[20:16], rd instr[15:11], shift amount instr[10:6], function instr[5:0] and the immediate instr[15:0]. Opcode-0 results target rd. Immediate-format results target instr[20:16], and `src_b` has no effect on them.
- R2: With opcode 0, function 0x20 and 0x21 give src_a+src_b, and 0x22 and 0x23 give src_a-src_b, both modulo 2^32.
- R3: With opcode 0, function 0x24/0x25/0x26/0x27 give the bitwise AND/OR/XOR/NOR of src_a and src_b.
- R4: With opcode 0, function 0x00/0x02/0x03 shift src_b left logical, right logical or right arithmetic by instr[10:6]. Function 0x04/0x06/0x07 do the same shifts by src_a[4:0].
- R5: With opcode 0, function 0x2A gives 1 when src_a < src_b as signed values and 0 otherwise. Function 0x2B does the same comparison on unsigned values.
- R6: Opcode 0x08 gives src_a plus the sign-extended immediate. Opcode 0x09 gives src_a plus the zero-extended immediate.
- R7: Opcodes 0x0C/0x0D/0x0E give the AND/OR/XOR of src_a with the zero-extended immediate.
- R8: Opcode 0x0A gives 1 when src_a < sign-extended immediate as signed values. Opcode 0x0B sign-extends the immediate and then compares both values as unsigned. In both cases the result is 0 otherwise.
- R9: Opcode 0x0F gives the immediate in bits [31:16] and zeros in bits [15:0], whatever the value of src_a.
- R10: A legal instruction whose destination index is 0 still presents its result, but `wr_en` is 0. Any other legal instruction has `wr_en` = 1.
- R11: Every opcode other than 0 and 0x08–0x0F is illegal, and so is opcode 0 with a function not listed in R2–R5. An illegal instruction sets `illegal` = 1 and gives `wr_en` = 0, `result` = 0 and `dest` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr | input | 32 | Instruction word |
| src_a | input | 32 | Value of the register named by instr[25:21] |
| src_b | input | 32 | Value of the register named by instr[20:16] |
| result | output | 32 | Computed result |
| dest | output | 5 | Destination register index |
| wr_en | output | 1 | Register write-enable |
| illegal | output | 1 | Unknown opcode or function |

## Verification
The bound checker tests the following properties whenever the inputs change:
- An illegal or zero-destination instruction never raises the write-enable.
- Every legal write to a non-zero register raises it.
- Comparison results are only ever 0 or 1.
- Upper-immediate results have a zero low half that carries the constant in its upper half.
- Adding a zero register leaves the other operand unchanged.
- The destination follows the format rule.

Only the bench scenarios can show that each operation computes the right value. These cover:
- wraparound in add and subtract
- sign fill on arithmetic shifts
- the variable-shift amount coming from src_a[4:0] rather than the shift field
- a sign-extended constant compared as unsigned
- the complete map of legal and illegal opcode and function codes

// File: rtl/int_exec_unit.sv
module int_exec_unit (
  input  logic [31:0] instr,
  input  logic [31:0] src_a,
  input  logic [31:0] src_b,
  output logic [31:0] result,
  output logic [4:0]  dest,
  output logic        wr_en,
  output logic        illegal
);
  localparam logic [5:0] OP_REG   = 6'h00;
  localparam logic [5:0] OP_ADDI  = 6'h08;
  localparam logic [5:0] OP_ADDIU = 6'h09;
  localparam logic [5:0] OP_SLTI  = 6'h0A;
  localparam logic [5:0] OP_SLTIU = 6'h0B;
  localparam logic [5:0] OP_ANDI  = 6'h0C;
  localparam logic [5:0] OP_ORI   = 6'h0D;
  localparam logic [5:0] OP_XORI  = 6'h0E;
  localparam logic [5:0] OP_LUI   = 6'h0F;

  localparam logic [5:0] FN_SLL  = 6'h00;
  localparam logic [5:0] FN_SRL  = 6'h02;
  localparam logic [5:0] FN_SRA  = 6'h03;
  localparam logic [5:0] FN_SLLV = 6'h04;
  localparam logic [5:0] FN_SRLV = 6'h06;
  localparam logic [5:0] FN_SRAV = 6'h07;
  localparam logic [5:0] FN_ADD  = 6'h20;
  localparam logic [5:0] FN_ADDU = 6'h21;
  localparam logic [5:0] FN_SUB  = 6'h22;
  localparam logic [5:0] FN_SUBU = 6'h23;
  localparam logic [5:0] FN_AND  = 6'h24;
  localparam logic [5:0] FN_OR   = 6'h25;
  localparam logic [5:0] FN_XOR  = 6'h26;
  localparam logic [5:0] FN_NOR  = 6'h27;
  localparam logic [5:0] FN_SLT  = 6'h2A;
  localparam logic [5:0] FN_SLTU = 6'h2B;

  wire [5:0]  opc   = instr[31:26];
  wire [4:0]  f_rt  = instr[20:16];
  wire [4:0]  f_rd  = instr[15:11];
  wire [4:0]  shamt = instr[10:6];
  wire [5:0]  func  = instr[5:0];
  wire [15:0] imm   = instr[15:0];

  wire [31:0] imm_sx = {{16{imm[15]}}, imm};
  wire [31:0] imm_zx = {16'h0000, imm};
  wire [4:0]  vamt   = src_a[4:0];

  logic [31:0] res;
  logic        bad;
  logic        to_rd;

  always_comb begin
    res   = '0;
    bad   = 1'b0;
    to_rd = 1'b0;
    if (opc == OP_REG) begin
      to_rd = 1'b1;
      case (func)
        FN_SLL:          res = src_b << shamt;
        FN_SRL:          res = src_b >> shamt;
        FN_SRA:          res = $unsigned($signed(src_b) >>> shamt);
        FN_SLLV:         res = src_b << vamt;
        FN_SRLV:         res = src_b >> vamt;
        FN_SRAV:         res = $unsigned($signed(src_b) >>> vamt);
        FN_ADD, FN_ADDU: res = src_a + src_b;
        FN_SUB, FN_SUBU: res = src_a - src_b;
        FN_AND:          res = src_a & src_b;
        FN_OR:           res = src_a | src_b;
        FN_XOR:          res = src_a ^ src_b;
        FN_NOR:          res = ~(src_a | src_b);
        FN_SLT:          res = {31'b0, $signed(src_a) < $signed(src_b)};
        FN_SLTU:         res = {31'b0, src_a < src_b};
        default:         bad = 1'b1;
      endcase
    end else begin
      case (opc)
        OP_ADDI:  res = src_a + imm_sx;
        OP_ADDIU: res = src_a + imm_zx;
        OP_SLTI:  res = {31'b0, $signed(src_a) < $signed(imm_sx)};
        OP_SLTIU: res = {31'b0, src_a < imm_sx};
        OP_ANDI:  res = src_a & imm_zx;
        OP_ORI:   res = src_a | imm_zx;
        OP_XORI:  res = src_a ^ imm_zx;
        OP_LUI:   res = {imm, 16'h0000};
        default:  bad = 1'b1;
      endcase
    end
  end

  assign result  = res;
  assign illegal = bad;
  assign dest    = bad ? 5'd0 : (to_rd ? f_rd : f_rt);
  assign wr_en   = !bad && (dest != 5'd0);
endmodule

// File: rtl/int_exec_unit_chk.sv
module int_exec_unit_chk (
  input logic [31:0] instr,
  input logic [31:0] src_a,
  input logic [31:0] src_b,
  input logic [31:0] result,
  input logic [4:0]  dest,
  input logic        wr_en,
  input logic        illegal
);
  wire [5:0] opc = instr[31:26];
  wire [5:0] fn  = instr[5:0];
  wire is_cmp = (opc == 6'h0A) || (opc == 6'h0B) ||
                ((opc == 6'h00) && ((fn == 6'h2A) || (fn == 6'h2B)));

  always_comb begin
    AST_ILLEGAL_NO_WRITE: assert (!(illegal && wr_en)) else $error("illegal op wrote"); // R11
    AST_ILLEGAL_ZERO_OUT: assert (!illegal || (result == 32'h0 && dest == 5'd0)) else $error("illegal op outputs"); // R11
    AST_ZERO_DEST_NO_WRITE: assert (!(dest == 5'd0 && wr_en)) else $error("write to register 0"); // R10
    AST_LEGAL_WRITES: assert (illegal || dest == 5'd0 || wr_en) else $error("legal op missing write"); // R10
    AST_CMP_IS_BOOL: assert (!is_cmp || result[31:1] == 31'h0) else $error("compare not 0/1"); // R5
    AST_UPPER_IMM_SHAPE: assert (opc != 6'h0F || result == {instr[15:0], 16'h0}) else $error("upper imm shape"); // R9
    AST_ADD_ZERO_IDENT: assert (!(opc == 6'h00 && fn == 6'h20 && src_b == 32'h0) || result == src_a) else $error("add zero"); // R2
    AST_DEST_FORMAT: assert (illegal || dest == (opc == 6'h00 ? instr[15:11] : instr[20:16])) else $error("dest field"); // R1
  end
endmodule

bind int_exec_unit int_exec_unit_chk u_chk (.*);

// File: tb/tb_int_exec_unit.sv
module tb_int_exec_unit;
  typedef struct packed {
    logic [3:0]  req;
    logic [31:0] ins;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] res;
    logic [4:0]  dst;
    logic        we;
    logic        ill;
  } vec_t;

  function automatic logic [31:0] rfmt(input logic [4:0] rs, input logic [4:0] rt,
                                       input logic [4:0] rd, input logic [4:0] sh,
                                       input logic [5:0] fn);
    return {6'h00, rs, rt, rd, sh, fn};
  endfunction

  function automatic logic [31:0] ifmt(input logic [5:0] op, input logic [4:0] rs,
                                       input logic [4:0] rt, input logic [15:0] im);
    return {op, rs, rt, im};
  endfunction

  localparam int NV = 36;
  localparam vec_t VEC [NV] = '{
    '{4'd2,  rfmt(5'd1, 5'd2, 5'd3, 5'd0, 6'h20), 32'd5, 32'd7, 32'd12, 5'd3, 1'b1, 1'b0},                       // R2 add
    '{4'd2,  rfmt(5'd1, 5'd2, 5'd4, 5'd0, 6'h21), 32'hFFFF_FFFF, 32'd2, 32'd1, 5'd4, 1'b1, 1'b0},                 // R2 wrap
    '{4'd2,  rfmt(5'd1, 5'd2, 5'd5, 5'd0, 6'h22), 32'd10, 32'd20, 32'hFFFF_FFF6, 5'd5, 1'b1, 1'b0},               // R2 sub
    '{4'd2,  rfmt(5'd1, 5'd2, 5'd6, 5'd0, 6'h23), 32'd0, 32'd1, 32'hFFFF_FFFF, 5'd6, 1'b1, 1'b0},                 // R2 subu
    '{4'd3,  rfmt(5'd1, 5'd2, 5'd7, 5'd0, 6'h24), 32'hF0F0_1234, 32'h0FF0_FF00, 32'h00F0_1200, 5'd7, 1'b1, 1'b0},  // R3 and
    '{4'd3,  rfmt(5'd1, 5'd2, 5'd7, 5'd0, 6'h25), 32'hF0F0_1234, 32'h0FF0_FF00, 32'hFFF0_FF34, 5'd7, 1'b1, 1'b0},  // R3 or
    '{4'd3,  rfmt(5'd1, 5'd2, 5'd7, 5'd0, 6'h26), 32'hF0F0_1234, 32'h0FF0_FF00, 32'hFF00_ED34, 5'd7, 1'b1, 1'b0},  // R3 xor
    '{4'd3,  rfmt(5'd1, 5'd2, 5'd7, 5'd0, 6'h27), 32'h0, 32'h0000_FFFF, 32'hFFFF_0000, 5'd7, 1'b1, 1'b0},          // R3 nor
    '{4'd4,  rfmt(5'd1, 5'd2, 5'd8, 5'd4, 6'h00), 32'h0, 32'h8000_000F, 32'h0000_00F0, 5'd8, 1'b1, 1'b0},          // R4 sll
    '{4'd4,  rfmt(5'd1, 5'd2, 5'd8, 5'd8, 6'h02), 32'h0, 32'h8000_0000, 32'h0080_0000, 5'd8, 1'b1, 1'b0},          // R4 srl
    '{4'd4,  rfmt(5'd1, 5'd2, 5'd8, 5'd8, 6'h03), 32'h0, 32'h8000_0000, 32'hFF80_0000, 5'd8, 1'b1, 1'b0},          // R4 sra
    '{4'd4,  rfmt(5'd1, 5'd2, 5'd8, 5'd7, 6'h04), 32'h21, 32'd3, 32'd6, 5'd8, 1'b1, 1'b0},                         // R4 sllv
    '{4'd4,  rfmt(5'd1, 5'd2, 5'd8, 5'd0, 6'h06), 32'd4, 32'hF000_0000, 32'h0F00_0000, 5'd8, 1'b1, 1'b0},          // R4 srlv
    '{4'd4,  rfmt(5'd1, 5'd2, 5'd8, 5'd0, 6'h07), 32'd31, 32'h8000_0000, 32'hFFFF_FFFF, 5'd8, 1'b1, 1'b0},         // R4 srav
    '{4'd5,  rfmt(5'd1, 5'd2, 5'd9, 5'd0, 6'h2A), 32'hFFFF_FFFF, 32'd1, 32'd1, 5'd9, 1'b1, 1'b0},                  // R5 slt
    '{4'd5,  rfmt(5'd1, 5'd2, 5'd9, 5'd0, 6'h2B), 32'hFFFF_FFFF, 32'd1, 32'd0, 5'd9, 1'b1, 1'b0},                  // R5 sltu
    '{4'd5,  rfmt(5'd1, 5'd2, 5'd9, 5'd0, 6'h2A), 32'd5, 32'd5, 32'd0, 5'd9, 1'b1, 1'b0},                          // R5 equal
    '{4'd6,  ifmt(6'h08, 5'd11, 5'd9, 16'hFFFD), 32'd11, 32'h1234_5678, 32'd8, 5'd9, 1'b1, 1'b0},                  // R6 addi
    '{4'd6,  ifmt(6'h09, 5'd11, 5'd9, 16'hFFFD), 32'd0, 32'h1234_5678, 32'h0000_FFFD, 5'd9, 1'b1, 1'b0},           // R6 addiu
    '{4'd7,  ifmt(6'h0C, 5'd1, 5'd10, 16'h8723), 32'hFFFF_FFFF, 32'h1234_5678, 32'h0000_8723, 5'd10, 1'b1, 1'b0},  // R7 andi
    '{4'd7,  ifmt(6'h0D, 5'd1, 5'd10, 16'hABCD), 32'h5678_0000, 32'h1234_5678, 32'h5678_ABCD, 5'd10, 1'b1, 1'b0},  // R7 ori
    '{4'd7,  ifmt(6'h0E, 5'd1, 5'd10, 16'hFF12), 32'hFFFF_0000, 32'h1234_5678, 32'hFFFF_FF12, 5'd10, 1'b1, 1'b0},  // R7 xori
    '{4'd8,  ifmt(6'h0A, 5'd1, 5'd11, 16'hFFFF), 32'hFFFF_FFFE, 32'h0, 32'd1, 5'd11, 1'b1, 1'b0},                  // R8 slti
    '{4'd8,  ifmt(6'h0A, 5'd1, 5'd11, 16'h0005), 32'd5, 32'h0, 32'd0, 5'd11, 1'b1, 1'b0},                          // R8 slti eq
    '{4'd8,  ifmt(6'h0B, 5'd1, 5'd11, 16'hFFFF), 32'hFFFF_FFFE, 32'h0, 32'd1, 5'd11, 1'b1, 1'b0},                  // R8 sltiu
    '{4'd8,  ifmt(6'h0B, 5'd1, 5'd11, 16'h8000), 32'h0001_0000, 32'h0, 32'd1, 5'd11, 1'b1, 1'b0},                  // R8 sext then unsigned
    '{4'd9,  ifmt(6'h0F, 5'd1, 5'd5, 16'h5678), 32'hDEAD_BEEF, 32'hFFFF_FFFF, 32'h5678_0000, 5'd5, 1'b1, 1'b0},    // R9 lui
    '{4'd1,  rfmt(5'd1, 5'd9, 5'd12, 5'd0, 6'h20), 32'd1, 32'd2, 32'd3, 5'd12, 1'b1, 1'b0},                        // R1 rd field
    '{4'd1,  ifmt(6'h08, 5'd1, 5'd17, 16'h0001), 32'd1, 32'hFFFF_FFFF, 32'd2, 5'd17, 1'b1, 1'b0},                  // R1 rt field, src_b ignored
    '{4'd10, rfmt(5'd1, 5'd2, 5'd0, 5'd0, 6'h20), 32'd1, 32'd1, 32'd2, 5'd0, 1'b0, 1'b0},                          // R10 rd zero
    '{4'd10, ifmt(6'h08, 5'd1, 5'd0, 16'h0004), 32'd1, 32'd0, 32'd5, 5'd0, 1'b0, 1'b0},                            // R10 rt zero
    '{4'd11, ifmt(6'h23, 5'd1, 5'd2, 16'h0004), 32'd1, 32'd1, 32'd0, 5'd0, 1'b0, 1'b1},                            // R11 load opcode
    '{4'd11, rfmt(5'd1, 5'd2, 5'd3, 5'd0, 6'h01), 32'd1, 32'd1, 32'd0, 5'd0, 1'b0, 1'b1},                          // R11 fn 01
    '{4'd11, rfmt(5'd1, 5'd2, 5'd3, 5'd0, 6'h08), 32'd1, 32'd1, 32'd0, 5'd0, 1'b0, 1'b1},                          // R11 fn 08
    '{4'd11, ifmt(6'h10, 5'd1, 5'd2, 16'h0004), 32'd1, 32'd1, 32'd0, 5'd0, 1'b0, 1'b1},                            // R11 op 10
    '{4'd11, ifmt(6'h07, 5'd1, 5'd2, 16'h0004), 32'd1, 32'd1, 32'd0, 5'd0, 1'b0, 1'b1}                             // R11 op 07
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [31:0] instr, src_a, src_b, result;
  logic [4:0]  dest;
  logic        wr_en, illegal;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  int_exec_unit dut (
    .instr(instr), .src_a(src_a), .src_b(src_b),
    .result(result), .dest(dest), .wr_en(wr_en), .illegal(illegal)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] i, input logic [31:0] a, input logic [31:0] b);
    @(posedge clk);
    instr = i; src_a = a; src_b = b;
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    if (!rst) cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected < 20000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    instr = '0; src_a = '0; src_b = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 idle result", result, 32'h0);
    chk("R10 idle wr_en", {31'b0, wr_en}, 32'h0);
    chk("R11 idle illegal", {31'b0, illegal}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      string t;
      drive(VEC[i].ins, VEC[i].a, VEC[i].b);
      t = $sformatf("R%0d vec%0d", VEC[i].req, i);
      chk({t, " result"}, result, VEC[i].res);
      chk({t, " dest"}, {27'b0, dest}, {27'b0, VEC[i].dst});
      chk({t, " wr_en"}, {31'b0, wr_en}, {31'b0, VEC[i].we});
      chk({t, " illegal"}, {31'b0, illegal}, {31'b0, VEC[i].ill});
    end

    // R11 opcode map: only 0x08..0x0F legal besides 0
    for (int op = 1; op < 64; op++) begin
      logic exp_ill;
      exp_ill = !(op >= 8 && op <= 15);
      drive({op[5:0], 5'd1, 5'd2, 16'h0001}, 32'd3, 32'd4);
      chk($sformatf("R11 op %02h illegal", op), {31'b0, illegal}, {31'b0, exp_ill});
      chk($sformatf("R11 op %02h wr_en", op), {31'b0, wr_en}, {31'b0, !exp_ill});
    end

    // R11 function map under opcode 0
    for (int f = 0; f < 64; f++) begin
      logic ok;
      ok = (f == 0) || (f == 2) || (f == 3) || (f == 4) || (f == 6) || (f == 7) ||
           (f >= 32 && f <= 39) || (f == 42) || (f == 43);
      drive({6'h00, 5'd1, 5'd2, 5'd3, 5'd1, f[5:0]}, 32'd3, 32'd4);
      chk($sformatf("R11 fn %02h illegal", f), {31'b0, illegal}, {31'b0, !ok});
      chk($sformatf("R11 fn %02h wr_en", f), {31'b0, wr_en}, {31'b0, ok});
    end

    // R4 every shift amount, fixed and variable forms
    for (int s = 0; s < 32; s++) begin
      logic [31:0] v, sra_e;
      v = 32'h8765_4321;
      sra_e = v >> s;
      for (int k = 0; k < 32; k++) if (k >= 32 - s) sra_e[k] = 1'b1;
      drive(rfmt(5'd1, 5'd2, 5'd3, s[4:0], 6'h00), 32'h0, v);
      chk($sformatf("R4 sll %0d", s), result, v << s);
      drive(rfmt(5'd1, 5'd2, 5'd3, s[4:0], 6'h02), 32'h0, v);
      chk($sformatf("R4 srl %0d", s), result, v >> s);
      drive(rfmt(5'd1, 5'd2, 5'd3, 5'd0, 6'h07), {27'h5A5A5A5, s[4:0]}, v);
      chk($sformatf("R4 srav %0d", s), result, sra_e);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule